// File: doc/BRIEF.md
# Instruction Length Decoder for a Variable-Length CISC Subset

This block sizes one instruction at the head of a byte-aligned fetch window. The window holds up to fifteen bytes, lowest address in the least significant byte. The block works through the bytes in encoding order, and each step decides how many bytes come next. First it skips any leading prefix bytes and records what they ask for. Next it finds the opcode, which is either one byte or an escape byte plus a second byte. It then decides whether an operand-addressing byte follows, whether that byte brings a scaled-index byte, and how long the displacement and the immediate are.

Each result reports the total length and the position of every field. It also carries the prefix summary, the opcode, an error for an instruction that is too long, and a flag for opcodes the block does not support. The supported table is the addition family, with 32-bit operands by default. The front end that loads the next window uses the length to advance its byte pointer.

The decode itself is combinational over the whole window. Its result is captured in a single output register that uses a valid/ready handshake.

Top module: `ild_top`

## Requirements
- R1: Leading bytes F0h, F3h, F2h, 66h and 67h set `out_pfx_flags` bits 0, 1, 2, 3 and 4 respectively. Segment overrides 26h, 2Eh, 36h, 3Eh, 64h and 65h set `out_seg` to 1, 2, 3, 4, 5 and 6, and the last one seen wins. With no segment override, `out_seg` is 0.
- R2: When more than 4 prefix bytes lead the window, `out_len_err` is 1. The prefix count equals `out_opc_ofs`.
- R3: When the opcode byte is 0Fh, `out_two_byte` is 1, `out_opcode` is the byte that follows, `out_unsup` is 1, and the length is the opcode offset plus 2.
- R4: The supported opcodes are 00h–03h (addressing byte, no immediate), 04h, 05h, 80h, 81h and 83h. Any other single-byte opcode sets `out_unsup`, has no further fields, and has a length of the opcode offset plus 1.
- R5: A scaled-index byte is present only when an addressing byte is present, its top two bits (mode) are not 11b, and its low three bits are 100b.
- R6: The displacement size is set by the mode bits of the addressing byte. Mode 01b gives 1 byte and mode 10b gives 4 bytes. Mode 00b gives 4 bytes when the low three bits are 101b, or when the index byte's low three bits are 101b; otherwise it gives 0. Mode 11b gives 0.
- R7: The immediate size is 1 byte for 04h, 80h and 83h. For 05h and 81h it is 4 bytes, or 2 bytes when 66h is among the prefixes. All other opcodes have no immediate.
- R8: The fields are laid out in this order: opcode, addressing byte, index byte, displacement, immediate. Each offset is the previous offset plus the size of the previous field (an absent field has size 0), and `out_len` is the end of the immediate.
- R9: When the total length exceeds 15, `out_len_err` is 1. When there are at most 4 prefixes and the length is at most 15, it is 0.
- R10: For 80h, 81h and 83h, an addressing byte whose bits 5:3 are not 000b sets `out_unsup`. So does 67h combined with a memory-mode addressing byte. In both cases the field sizes are still decoded.
- R11: A window accepted while `in_valid && in_ready` is presented on the outputs one cycle later. While `out_valid && !out_ready`, the outputs hold unchanged. `in_ready` is high whenever the output register is empty or is being drained.
- R12: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Window is valid |
| in_ready | output | 1 | Block can take a window |
| in_bytes | input | 120 | Fetch window, byte 0 in bits 7:0 |
| out_valid | output | 1 | Decode result is valid |
| out_ready | input | 1 | Consumer takes the result |
| out_len | output | 5 | Total instruction length in bytes |
| out_len_err | output | 1 | Too many prefixes or length above 15 |
| out_unsup | output | 1 | Opcode or form outside the supported table |
| out_pfx_flags | output | 5 | Lock, rep, repne, operand-size, address-size |
| out_seg | output | 3 | Segment override code, 0 for none |
| out_two_byte | output | 1 | Escape opcode seen |
| out_opcode | output | 8 | Opcode byte (the second byte after an escape) |
| out_has_modrm | output | 1 | Addressing byte present |
| out_has_sib | output | 1 | Scaled-index byte present |
| out_disp_len | output | 3 | Displacement bytes |
| out_imm_len | output | 3 | Immediate bytes |
| out_opc_ofs | output | 5 | Offset of the first opcode byte |
| out_modrm_ofs | output | 5 | Offset of the addressing byte |
| out_sib_ofs | output | 5 | Offset of the index byte |
| out_disp_ofs | output | 5 | Offset of the displacement |
| out_imm_ofs | output | 5 | Offset of the immediate |

## Verification
The assertions assume that `in_valid` and `in_bytes` are only sampled at an accepting edge, and that the consumer may hold `out_ready` low for any number of cycles. The bench drives inputs just after each rising edge and changes a window only once it has been accepted. Random backpressure on `out_ready` exercises the hold rule. The decode itself places no restriction on the window contents. Directed windows cover the boundary forms: four and five prefixes, a fifteen-byte maximum, a seventeen-byte overrun, escape opcodes and forbidden group selectors. Random windows mix zero to six prefixes with every supported and several unsupported opcodes.

// File: rtl/ild_pkg.sv
// Package: shared types and byte classifiers for the instruction length decoder.
// Assumes 32-bit default operand and address size.
package ild_pkg;

    localparam int unsigned ILD_OFS_W = 5;   // offsets/length; holds worst case 27
    localparam int unsigned ILD_FLD_W = 3;   // displacement / immediate size field
    localparam logic [7:0]  ILD_ESCAPE = 8'h0F;

    typedef enum logic [2:0] {
        PK_NONE, PK_LOCK, PK_REP, PK_REPNE, PK_OPSZ, PK_ADSZ, PK_SEG
    } ild_pfx_kind_e;

    typedef enum logic [2:0] {
        SEG_NONE = 3'd0, SEG_ES = 3'd1, SEG_CS = 3'd2, SEG_SS = 3'd3,
        SEG_DS = 3'd4, SEG_FS = 3'd5, SEG_GS = 3'd6
    } ild_seg_e;

    typedef struct packed {
        logic adsz;
        logic opsz;
        logic repne;
        logic rep;
        logic lock;
    } ild_pfx_t;

    typedef struct packed {
        logic [ILD_OFS_W-1:0] len;
        logic                 len_err;
        logic                 unsup;
        ild_pfx_t             pfx;
        ild_seg_e             seg;
        logic                 two_byte;
        logic [7:0]           opcode;
        logic                 has_modrm;
        logic                 has_sib;
        logic [ILD_FLD_W-1:0] disp_len;
        logic [ILD_FLD_W-1:0] imm_len;
        logic [ILD_OFS_W-1:0] ofs_opc;
        logic [ILD_OFS_W-1:0] ofs_modrm;
        logic [ILD_OFS_W-1:0] ofs_sib;
        logic [ILD_OFS_W-1:0] ofs_disp;
        logic [ILD_OFS_W-1:0] ofs_imm;
    } ild_dec_t;

    // Classify one byte as a prefix kind (PK_NONE if not a prefix).
    function automatic ild_pfx_kind_e pfx_kind(input logic [7:0] b);
        case (b)
            8'hF0:                                    return PK_LOCK;
            8'hF3:                                    return PK_REP;
            8'hF2:                                    return PK_REPNE;
            8'h66:                                    return PK_OPSZ;
            8'h67:                                    return PK_ADSZ;
            8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65: return PK_SEG;
            default:                                  return PK_NONE;
        endcase
    endfunction

    // Map a segment override byte to its code.
    function automatic ild_seg_e seg_code(input logic [7:0] b);
        case (b)
            8'h26:   return SEG_ES;
            8'h2E:   return SEG_CS;
            8'h36:   return SEG_SS;
            8'h3E:   return SEG_DS;
            8'h64:   return SEG_FS;
            8'h65:   return SEG_GS;
            default: return SEG_NONE;
        endcase
    endfunction

endpackage

// File: rtl/ild_prefix_scan.sv
// Prefix scanner: counts the run of prefix bytes at the start of the window
// and merges their effects. Assumes byte 0 is the first instruction byte.
module ild_prefix_scan
    import ild_pkg::*;
#(
    parameter int unsigned WIN_BYTES = 15,
    parameter int unsigned CNT_W     = 5
) (
    input  logic [WIN_BYTES*8-1:0] win,
    output logic [CNT_W-1:0]       pfx_cnt,
    output ild_pfx_t               flags,
    output ild_seg_e               seg
);

    ild_pfx_kind_e kind [WIN_BYTES];

    // Classify every window byte in parallel.
    generate
        for (genvar g = 0; g < WIN_BYTES; g++) begin : g_cls
            assign kind[g] = pfx_kind(win[g*8 +: 8]);
        end
    endgenerate

    // Walk the leading prefix run; the last segment override wins.
    always_comb begin
        logic run;
        run     = 1'b1;
        pfx_cnt = '0;
        flags   = '0;
        seg     = SEG_NONE;
        for (int i = 0; i < WIN_BYTES; i++) begin
            if (run && (kind[i] != PK_NONE)) begin
                pfx_cnt = pfx_cnt + CNT_W'(1);
                case (kind[i])
                    PK_LOCK:  flags.lock  = 1'b1;
                    PK_REP:   flags.rep   = 1'b1;
                    PK_REPNE: flags.repne = 1'b1;
                    PK_OPSZ:  flags.opsz  = 1'b1;
                    PK_ADSZ:  flags.adsz  = 1'b1;
                    PK_SEG:   seg         = seg_code(win[i*8 +: 8]);
                    default:  ;
                endcase
            end else begin
                run = 1'b0;
            end
        end
    end

endmodule

// File: rtl/ild_field_size.sv
// Field sizer: from the opcode byte and the two bytes after it, decides
// the opcode width, presence of the addressing and index bytes, and the
// displacement and immediate sizes. Assumes 32-bit addressing rules.
module ild_field_size
    import ild_pkg::*;
(
    input  logic [7:0]           byte0,     // first opcode byte
    input  logic [7:0]           byte1,     // addressing byte or escaped opcode
    input  logic [2:0]           sib_base,  // low bits of the byte after byte1
    input  logic                 opsz,
    input  logic                 adsz,
    output logic [7:0]           opcode,
    output logic                 two_byte,
    output logic                 has_modrm,
    output logic                 has_sib,
    output logic [ILD_FLD_W-1:0] disp_len,
    output logic [ILD_FLD_W-1:0] imm_len,
    output logic                 unsup
);

    logic [1:0]           mode;
    logic [2:0]           sel;
    logic [2:0]           rm;
    logic                 grp_imm;
    logic                 tbl_miss;
    logic [ILD_FLD_W-1:0] full_imm;

    assign mode     = byte1[7:6];
    assign sel      = byte1[5:3];
    assign rm       = byte1[2:0];
    assign full_imm = opsz ? ILD_FLD_W'(2) : ILD_FLD_W'(4);

    // Opcode table lookup.
    always_comb begin
        two_byte  = (byte0 == ILD_ESCAPE);
        opcode    = two_byte ? byte1 : byte0;
        has_modrm = 1'b0;
        imm_len   = '0;
        grp_imm   = 1'b0;
        tbl_miss  = 1'b0;
        if (two_byte) begin
            tbl_miss = 1'b1;
        end else begin
            case (byte0)
                8'h00, 8'h01, 8'h02, 8'h03: has_modrm = 1'b1;
                8'h04: imm_len = ILD_FLD_W'(1);
                8'h05: imm_len = full_imm;
                8'h80, 8'h83: begin
                    has_modrm = 1'b1;
                    imm_len   = ILD_FLD_W'(1);
                    grp_imm   = 1'b1;
                end
                8'h81: begin
                    has_modrm = 1'b1;
                    imm_len   = full_imm;
                    grp_imm   = 1'b1;
                end
                default: tbl_miss = 1'b1;
            endcase
        end
    end

    // Addressing byte decode: index byte presence and displacement size.
    always_comb begin
        has_sib  = has_modrm && (mode != 2'b11) && (rm == 3'b100);
        disp_len = '0;
        if (has_modrm) begin
            case (mode)
                2'b01: disp_len = ILD_FLD_W'(1);
                2'b10: disp_len = ILD_FLD_W'(4);
                2'b00: if ((rm == 3'b101) || (has_sib && (sib_base == 3'b101)))
                           disp_len = ILD_FLD_W'(4);
                default: disp_len = '0;
            endcase
        end
    end

    // Unsupported forms: table miss, foreign group selector, 16-bit addressing.
    assign unsup = tbl_miss
                 || (grp_imm && (sel != 3'b000))
                 || (has_modrm && adsz && (mode != 2'b11));

endmodule

// File: rtl/ild_out_stage.sv
// Output register with a valid/ready handshake. Assumes the consumer may
// stall indefinitely; the held result stays stable while stalled.
module ild_out_stage
    import ild_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     in_valid,
    output logic     in_ready,
    input  ild_dec_t d,
    output logic     out_valid,
    input  logic     out_ready,
    output ild_dec_t q
);

    assign in_ready = !out_valid || out_ready;

    // Track whether the register holds an undelivered result.
    always_ff @(posedge clk) begin
        if (!rst_n)            out_valid <= 1'b0;
        else if (in_ready)     out_valid <= in_valid;
    end

    // Capture a new result on every accepted window.
    always_ff @(posedge clk) begin
        if (!rst_n)                    q <= '0;
        else if (in_valid && in_ready) q <= d;
    end

endmodule

// File: rtl/ild_top.sv
// Instruction length decoder top: prefix scan, opcode/field sizing, offset
// chain, error detection, and registered output. Assumes byte 0 of the
// window is the first byte of an instruction; bytes past the window read 0.
module ild_top
    import ild_pkg::*;
#(
    parameter int unsigned WIN_BYTES = 15,
    parameter int unsigned MAX_LEN   = 15,
    parameter int unsigned MAX_PFX   = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [WIN_BYTES*8-1:0] in_bytes,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [ILD_OFS_W-1:0]   out_len,
    output logic                   out_len_err,
    output logic                   out_unsup,
    output logic [4:0]             out_pfx_flags,
    output logic [2:0]             out_seg,
    output logic                   out_two_byte,
    output logic [7:0]             out_opcode,
    output logic                   out_has_modrm,
    output logic                   out_has_sib,
    output logic [ILD_FLD_W-1:0]   out_disp_len,
    output logic [ILD_FLD_W-1:0]   out_imm_len,
    output logic [ILD_OFS_W-1:0]   out_opc_ofs,
    output logic [ILD_OFS_W-1:0]   out_modrm_ofs,
    output logic [ILD_OFS_W-1:0]   out_sib_ofs,
    output logic [ILD_OFS_W-1:0]   out_disp_ofs,
    output logic [ILD_OFS_W-1:0]   out_imm_ofs
);

    localparam int unsigned OFS_W = ILD_OFS_W;

    logic [OFS_W-1:0]     pfx_cnt;
    ild_pfx_t             pfx;
    ild_seg_e             seg;
    logic [7:0]           b0, b1, b2;
    logic [7:0]           opcode;
    logic                 two_byte, has_modrm, has_sib, unsup;
    logic [ILD_FLD_W-1:0] disp_len, imm_len;
    logic [OFS_W-1:0]     ofs_modrm, ofs_sib, ofs_disp, ofs_imm, total;
    ild_dec_t             dec, held;

    // Byte selector with zero fill past the end of the window.
    function automatic logic [7:0] pick(input logic [WIN_BYTES*8-1:0] w,
                                        input logic [OFS_W-1:0] idx);
        logic [7:0] r;
        r = 8'h00;
        for (int i = 0; i < WIN_BYTES; i++)
            if (idx == OFS_W'(i)) r = w[i*8 +: 8];
        return r;
    endfunction

    ild_prefix_scan #(.WIN_BYTES(WIN_BYTES), .CNT_W(OFS_W)) u_scan (
        .win     (in_bytes),
        .pfx_cnt (pfx_cnt),
        .flags   (pfx),
        .seg     (seg)
    );

    // Fetch the opcode byte and the two bytes that may follow it.
    always_comb begin
        b0 = pick(in_bytes, pfx_cnt);
        b1 = pick(in_bytes, pfx_cnt + OFS_W'(1));
        b2 = pick(in_bytes, pfx_cnt + OFS_W'(2));
    end

    ild_field_size u_size (
        .byte0     (b0),
        .byte1     (b1),
        .sib_base  (b2[2:0]),
        .opsz      (pfx.opsz),
        .adsz      (pfx.adsz),
        .opcode    (opcode),
        .two_byte  (two_byte),
        .has_modrm (has_modrm),
        .has_sib   (has_sib),
        .disp_len  (disp_len),
        .imm_len   (imm_len),
        .unsup     (unsup)
    );

    // Offset chain: each field starts where the previous one ends.
    always_comb begin
        ofs_modrm = pfx_cnt + (two_byte ? OFS_W'(2) : OFS_W'(1));
        ofs_sib   = ofs_modrm + OFS_W'(has_modrm);
        ofs_disp  = ofs_sib + OFS_W'(has_sib);
        ofs_imm   = ofs_disp + OFS_W'(disp_len);
        total     = ofs_imm + OFS_W'(imm_len);
    end

    // Assemble the decode record, including the length error.
    always_comb begin
        dec           = '0;
        dec.len       = total;
        dec.len_err   = (pfx_cnt > OFS_W'(MAX_PFX)) || (total > OFS_W'(MAX_LEN));
        dec.unsup     = unsup;
        dec.pfx       = pfx;
        dec.seg       = seg;
        dec.two_byte  = two_byte;
        dec.opcode    = opcode;
        dec.has_modrm = has_modrm;
        dec.has_sib   = has_sib;
        dec.disp_len  = disp_len;
        dec.imm_len   = imm_len;
        dec.ofs_opc   = pfx_cnt;
        dec.ofs_modrm = ofs_modrm;
        dec.ofs_sib   = ofs_sib;
        dec.ofs_disp  = ofs_disp;
        dec.ofs_imm   = ofs_imm;
    end

    ild_out_stage u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .d         (dec),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .q         (held)
    );

    // Drive the flat output ports from the held record.
    always_comb begin
        out_len       = held.len;
        out_len_err   = held.len_err;
        out_unsup     = held.unsup;
        out_pfx_flags = held.pfx;
        out_seg       = held.seg;
        out_two_byte  = held.two_byte;
        out_opcode    = held.opcode;
        out_has_modrm = held.has_modrm;
        out_has_sib   = held.has_sib;
        out_disp_len  = held.disp_len;
        out_imm_len   = held.imm_len;
        out_opc_ofs   = held.ofs_opc;
        out_modrm_ofs = held.ofs_modrm;
        out_sib_ofs   = held.ofs_sib;
        out_disp_ofs  = held.ofs_disp;
        out_imm_ofs   = held.ofs_imm;
    end

endmodule

// File: rtl/ild_checker.sv
// Assertion checker for ild_top, attached with bind below.
module ild_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_ready,
    input logic       out_valid,
    input logic       out_ready,
    input logic [4:0] out_len,
    input logic       out_len_err,
    input logic       out_unsup,
    input logic       out_two_byte,
    input logic [7:0] out_opcode,
    input logic       out_has_modrm,
    input logic       out_has_sib,
    input logic [4:0] out_opc_ofs,
    input logic [4:0] out_modrm_ofs,
    input logic [4:0] out_sib_ofs,
    input logic [4:0] out_disp_ofs,
    input logic [4:0] out_imm_ofs
);

    assert_accept_shows_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    assert_stall_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_len)
            && $stable(out_opcode) && $stable(out_imm_ofs)));

    assert_sib_needs_modrm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_has_sib) |-> out_has_modrm);

    assert_escape_unsup_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_two_byte) |-> out_unsup);

    assert_field_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_opc_ofs < out_modrm_ofs) && (out_modrm_ofs <= out_sib_ofs)
            && (out_sib_ofs <= out_disp_ofs) && (out_disp_ofs <= out_imm_ofs)
            && (out_imm_ofs <= out_len)));

    assert_prefix_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (out_opc_ofs > 5'd4)) |-> out_len_err);

    assert_no_overlength_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (out_len > 5'd15)) |-> out_len_err);

endmodule

bind ild_top ild_checker chk_i (.*);

// File: tb/ild_top_tb_top.sv
// Bench: behavioural reference model with a queue of expected results,
// compared at every falling edge against the design's outputs.
module ild_top_tb_top;

    typedef struct {
        int         len;
        bit         lerr;
        bit         unsup;
        logic [4:0] flags;
        int         seg;
        bit         two;
        logic [7:0] opc;
        bit         hm;
        bit         hs;
        int         dl;
        int         il;
        int         o_opc;
        int         o_mrm;
        int         o_sib;
        int         o_dsp;
        int         o_imm;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [119:0] in_bytes = '0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [4:0]   out_len;
    logic         out_len_err, out_unsup;
    logic [4:0]   out_pfx_flags;
    logic [2:0]   out_seg;
    logic         out_two_byte;
    logic [7:0]   out_opcode;
    logic         out_has_modrm, out_has_sib;
    logic [2:0]   out_disp_len, out_imm_len;
    logic [4:0]   out_opc_ofs, out_modrm_ofs, out_sib_ofs, out_disp_ofs, out_imm_ofs;

    int   nchk = 0;
    int   nbad = 0;
    bit   finished = 1'b0;
    bit   rand_ready = 1'b0;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    ild_top dut_i (.*);

    function automatic logic [7:0] gb(input logic [119:0] w, input int i);
        return (i < 15) ? w[i*8 +: 8] : 8'h00;
    endfunction

    // Reference model written from the requirements.
    function automatic exp_t model(input logic [119:0] w);
        exp_t e;
        int n, cur;
        bit run;
        logic [7:0] op, m;
        int unsigned md, rm;
        e = '{default: 0};
        n = 0;
        run = 1'b1;
        for (int i = 0; i < 15; i++) begin
            if (run) begin
                case (gb(w, i))
                    8'hF0: e.flags[0] = 1'b1;
                    8'hF3: e.flags[1] = 1'b1;
                    8'hF2: e.flags[2] = 1'b1;
                    8'h66: e.flags[3] = 1'b1;
                    8'h67: e.flags[4] = 1'b1;
                    8'h26: e.seg = 1;
                    8'h2E: e.seg = 2;
                    8'h36: e.seg = 3;
                    8'h3E: e.seg = 4;
                    8'h64: e.seg = 5;
                    8'h65: e.seg = 6;
                    default: run = 1'b0;
                endcase
                if (run) n++;
            end
        end
        e.o_opc = n;
        op = gb(w, n);
        if (op == 8'h0F) begin
            e.two = 1'b1; e.opc = gb(w, n + 1); e.unsup = 1'b1; cur = n + 2;
        end else begin
            e.opc = op; cur = n + 1;
            case (op)
                8'h00, 8'h01, 8'h02, 8'h03: e.hm = 1'b1;
                8'h04: e.il = 1;
                8'h05: e.il = e.flags[3] ? 2 : 4;
                8'h80, 8'h83: begin e.hm = 1'b1; e.il = 1; end
                8'h81: begin e.hm = 1'b1; e.il = e.flags[3] ? 2 : 4; end
                default: e.unsup = 1'b1;
            endcase
        end
        e.o_mrm = cur;
        if (e.hm) begin
            m  = gb(w, cur);
            md = m[7:6];
            rm = m[2:0];
            if ((op == 8'h80 || op == 8'h81 || op == 8'h83) && m[5:3] != 3'b000) e.unsup = 1'b1;
            if (e.flags[4] && md != 3) e.unsup = 1'b1;
            e.hs = (md != 3) && (rm == 4);
            if (md == 1) e.dl = 1;
            else if (md == 2) e.dl = 4;
            else if (md == 0 && (rm == 5 || (e.hs && gb(w, cur + 1 + 0 + 1 - 1)[2:0] == 3'b101))) e.dl = 4;
            cur++;
        end
        e.o_sib = cur;
        if (e.hs) cur++;
        e.o_dsp = cur;
        cur += e.dl;
        e.o_imm = cur;
        cur += e.il;
        e.len = cur;
        e.lerr = (n > 4) || (cur > 15);
        return e;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic compare(input exp_t e);
        chk(out_pfx_flags == e.flags, "R1 prefix flags", int'(out_pfx_flags), int'(e.flags));
        chk(int'(out_seg) == e.seg, "R1 segment code", int'(out_seg), e.seg);
        chk(out_len_err == e.lerr, "R2 R9 length error", int'(out_len_err), int'(e.lerr));
        chk(out_two_byte == e.two, "R3 escape flag", int'(out_two_byte), int'(e.two));
        chk(out_opcode == e.opc, "R3 opcode", int'(out_opcode), int'(e.opc));
        chk(out_unsup == e.unsup, "R4 R10 unsupported", int'(out_unsup), int'(e.unsup));
        chk(out_has_modrm == e.hm, "R4 addressing byte", int'(out_has_modrm), int'(e.hm));
        chk(out_has_sib == e.hs, "R5 index byte", int'(out_has_sib), int'(e.hs));
        chk(int'(out_disp_len) == e.dl, "R6 displacement size", int'(out_disp_len), e.dl);
        chk(int'(out_imm_len) == e.il, "R7 immediate size", int'(out_imm_len), e.il);
        chk(int'(out_len) == e.len, "R8 length", int'(out_len), e.len);
        chk(int'(out_opc_ofs) == e.o_opc && int'(out_modrm_ofs) == e.o_mrm
            && int'(out_sib_ofs) == e.o_sib && int'(out_disp_ofs) == e.o_dsp
            && int'(out_imm_ofs) == e.o_imm, "R8 offsets",
            int'({out_opc_ofs, out_modrm_ofs, out_sib_ofs, out_disp_ofs, out_imm_ofs}),
            (e.o_opc << 20) | (e.o_mrm << 15) | (e.o_sib << 10) | (e.o_dsp << 5) | e.o_imm);
    endtask

    // Per-clock monitor: latency and hold rules, then result comparison.
    bit acc_prev = 1'b0;
    bit stall_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (acc_prev || stall_prev)
                chk(out_valid == 1'b1, "R11 result present", int'(out_valid), 1);
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) chk(1'b0, "R11 unexpected result", 1, 0);
                else compare(exp_q.pop_front());
            end
            acc_prev   = in_valid && in_ready;
            stall_prev = out_valid && !out_ready;
            if (acc_prev) exp_q.push_back(model(in_bytes));
        end
    end

    // Backpressure driver.
    always @(posedge clk) begin
        #1;
        if (rand_ready) out_ready = ($urandom % 4) != 0;
        else            out_ready = 1'b1;
    end

    task automatic send(input logic [7:0] q[$]);
        logic [119:0] w;
        w = {15{8'h90}};
        for (int i = 0; i < q.size() && i < 15; i++) w[i*8 +: 8] = q[i];
        in_bytes = w;
        in_valid = 1'b1;
        do @(negedge clk); while (!in_ready);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic send_random();
        logic [7:0] q[$];
        logic [7:0] pf[$] = '{8'hF0, 8'hF3, 8'hF2, 8'h66, 8'h67, 8'h26, 8'h2E,
                              8'h36, 8'h3E, 8'h64, 8'h65};
        logic [7:0] ops[$] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h80,
                               8'h81, 8'h83, 8'h0F, 8'h82, 8'h90};
        int np;
        np = $urandom % 7;
        for (int i = 0; i < np; i++) q.push_back(pf[$urandom % pf.size()]);
        q.push_back(ops[$urandom % ops.size()]);
        while (q.size() < 15) q.push_back(8'($urandom));
        send(q);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R12 reset out_valid", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R12 reset in_ready", int'(in_ready), 1);
        @(posedge clk);
        #1;
        send('{8'h00, 8'hC1});                                   // R4 register form
        send('{8'h03, 8'hC8});
        send('{8'h66, 8'h05, 8'h34, 8'h12});                     // R7 2-byte imm
        send('{8'h04, 8'h7F});                                   // R7
        send('{8'h03, 8'h15, 8'h01, 8'h02, 8'h03, 8'h04});       // R6 absolute disp
        send('{8'h03, 8'h3B});
        send('{8'h03, 8'h46, 8'h08});                            // R6 disp8
        send('{8'h03, 8'h9D, 8'h01, 8'h02, 8'h03, 8'h04});       // R6 disp32
        send('{8'h03, 8'h2C, 8'h05, 8'h01, 8'h02, 8'h03, 8'h04});// R5 R6 no-base
        send('{8'h03, 8'h0C, 8'hBB});                            // R5
        send('{8'hF0, 8'h2E, 8'h66, 8'h67, 8'h81, 8'hC0, 8'h34, 8'h12}); // R1
        send('{8'h26, 8'h26, 8'h26, 8'h26, 8'h26, 8'h04, 8'h01});        // R2
        send('{8'hF3, 8'hF2, 8'h64, 8'h65, 8'h81, 8'h84, 8'h24, 8'h01,
               8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08});        // R9 exactly 15
        send('{8'h3E, 8'h3E, 8'h3E, 8'h3E, 8'h3E, 8'h3E, 8'h81, 8'h84,
               8'h24, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06});        // R9 overrun
        send('{8'h0F, 8'hA2});                                   // R3
        send('{8'h80, 8'hC8, 8'h01});                            // R10 selector
        send('{8'h67, 8'h03, 8'h00});                            // R10 address size
        send('{8'h82, 8'hC0, 8'h01});                            // R4 outside table
        send('{8'h83, 8'hC0, 8'hFF});
        send('{8'h36, 8'h3E, 8'h83, 8'h45, 8'h08, 8'h01});       // R1 last wins
        rand_ready = 1'b1;                                       // R11 backpressure
        for (int k = 0; k < 400; k++) send_random();
        while (exp_q.size() != 0) @(posedge clk);
        repeat (3) @(posedge clk);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            nchk++;
            nbad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

endmodule